// File: doc/BRIEF.md
# Bus Performance Counter Unit

This block sits next to one bus port and measures how busy it is. A free-running cycle counter provides the time base. Four event counters each tally read-data beats, write-data beats, or both, as picked by a per-counter select register. The beat inputs are single-cycle pulses from the port. Software reaches the unit through a small register bus. It arms individual counters through a pair of write-one-to-set and write-one-to-clear registers, and it starts or stops the whole unit with one global run bit. Two self-clearing command bits zero the event counters and the cycle counter.

To take a consistent sample, software drops the run bit and then reads the counters, which hold their values while the unit is halted. Counter 3 is wider than the others, so its value is read as a low word plus a separate high register.

The global run bit is a two-state machine. In **HALT**, no counter moves. In **RUN**, each armed counter advances. A control write with the run bit set takes HALT to RUN (transition *start*). A control write with the run bit clear takes RUN to HALT (transition *stop*). Any other cycle leaves the state where it is.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset the following all read as 0: the control register, the enable mask, every select register, the cycle counter, every event counter, and the counter-3 high register. `bus_rdata` is 0 during and after reset.
- R2: A write to EN_SET (0x04) sets each mask bit written as 1. A write to EN_CLR (0x08) clears each mask bit written as 1. Bits written as 0 leave the mask unchanged. Bits 0 to 3 arm event counters 0 to 3, and bit 4 arms the cycle counter. Reading either address returns the mask in bits 4:0.
- R3: The control register is at 0x00, and bit 0 is the global run bit; it reads back as the current state (RUN = 1). While in HALT no counter advances, even if its mask bit is set. A counter whose mask bit is 0 never advances.
- R4: While halted, every counter keeps its value, so repeated reads return the same numbers.
- R5: Writing 1 to control bit 1 zeroes all four event counters on the next clock edge. That clear wins over any beat counted in the same cycle. Bit 1 always reads 0.
- R6: Writing 1 to control bit 2 zeroes the cycle counter on the next clock edge. That clear wins over a count in the same cycle. Bit 2 always reads 0.
- R7: The select register of counter i is at 0x10+4*i. Bit 0 selects read beats and bit 1 selects write beats. With both bits set, a cycle that carries both pulses adds 2.
- R8: Counters 0 to 2 are CNT_W bits wide and are read at 0x24, 0x28 and 0x2C. Counter 3 is CNT_W+HI_W bits wide. Its low CNT_W bits are read at 0x30, and its upper HI_W bits are read at 0x34 in the lowest bits. Every counter wraps to 0 on overflow.
- R9: The cycle counter, read at 0x20, adds 1 on each clock in RUN while mask bit 4 is set, and it wraps to 0.
- R10: A read presented in one cycle returns its data on `bus_rdata` in the next cycle. In any cycle after a cycle with no read, `bus_rdata` is 0. Unmapped addresses read as 0.
- R11: A register write affects counting from the cycle after the write. A beat that arrives in the same cycle as the write is counted under the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the read |
| rd_beat | input | 1 | One-cycle pulse per read-data beat |
| wr_beat | input | 1 | One-cycle pulse per write-data beat |

## Verification
A stuck or wrong run state shows up at the ports on the very next read. Such a read gives a control value that differs from the last write, or counter values that move while halted or stay still while running. A corrupted mask bit or select register shows within one read. Either a counter's growth no longer matches the beats driven, or the register itself reads back wrong. Carry faults into the wide counter's upper part only show once the low part wraps. The bench therefore runs long enough, with reduced widths, to cross that boundary many times, and it compares every read-data cycle.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
    localparam int NUM_EVT     = 4;
    localparam int CYC_EN_BIT  = NUM_EVT;
    localparam int CTRL_RUN    = 0;
    localparam int CTRL_EVTCLR = 1;
    localparam int CTRL_CYCCLR = 2;
    localparam int SEL_RD      = 0;
    localparam int SEL_WR      = 1;

    localparam logic [7:0] A_CTRL     = 8'h00;
    localparam logic [7:0] A_EN_SET   = 8'h04;
    localparam logic [7:0] A_EN_CLR   = 8'h08;
    localparam logic [7:0] A_SEL_BASE = 8'h10;
    localparam logic [7:0] A_CYC      = 8'h20;
    localparam logic [7:0] A_EVT_BASE = 8'h24;
    localparam logic [7:0] A_WIDE_HI  = 8'h34;

    typedef enum logic {ST_HALT = 1'b0, ST_RUN = 1'b1} run_state_e;
endpackage

// File: rtl/pm_run_fsm.sv
module pm_run_fsm
    import perfmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic run_bit,
    output logic run
);
    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (ctrl_wr && run_bit)  state_d = ST_RUN;   // start
            ST_RUN:  if (ctrl_wr && !run_bit) state_d = ST_HALT;  // stop
        endcase
    end

    always_comb begin
        run = (state_q == ST_RUN);
    end
endmodule

// File: rtl/pm_enable_regs.sv
module pm_enable_regs #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_wr,
    input  logic         clr_wr,
    input  logic [N-1:0] bits,
    output logic [N-1:0] mask
);
    logic [N-1:0] set_v, clr_v;

    always_comb begin
        set_v = set_wr ? bits : '0;
        clr_v = clr_wr ? bits : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else        mask <= (mask | set_v) & ~clr_v;
    end
endmodule

// File: rtl/pm_counter.sv
module pm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [1:0]   inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else          count <= count + W'(inc);
    end
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
    import perfmon_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter int HI_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rd_beat,
    input  logic              wr_beat
);
    localparam int WIDE_W = CNT_W + HI_W;
    localparam int N_EN   = NUM_EVT + 1;

    logic              wr_any, rd_any;
    logic              wr_ctrl, wr_set, wr_clr;
    logic              run;
    logic [N_EN-1:0]   en_mask;
    logic [CNT_W-1:0]  cyc_cnt;
    logic [WIDE_W-1:0] wide_cnt;
    logic [1:0]        evt_sel [NUM_EVT];
    logic [WIDE_W-1:0] evt_val [NUM_EVT];
    logic [DATA_W-1:0] rd_mux;

    assign wr_any  = bus_valid && bus_write;
    assign rd_any  = bus_valid && !bus_write;
    assign wr_ctrl = wr_any && (bus_addr == ADDR_W'(A_CTRL));
    assign wr_set  = wr_any && (bus_addr == ADDR_W'(A_EN_SET));
    assign wr_clr  = wr_any && (bus_addr == ADDR_W'(A_EN_CLR));

    pm_run_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (wr_ctrl),
        .run_bit (bus_wdata[CTRL_RUN]),
        .run     (run)
    );

    pm_enable_regs #(.N(N_EN)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_wr (wr_set),
        .clr_wr (wr_clr),
        .bits   (bus_wdata[N_EN-1:0]),
        .mask   (en_mask)
    );

    pm_counter #(.W(CNT_W)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wr_ctrl && bus_wdata[CTRL_CYCCLR]),
        .inc   ({1'b0, run && en_mask[CYC_EN_BIT]}),
        .count (cyc_cnt)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        localparam int CW = (g == NUM_EVT - 1) ? WIDE_W : CNT_W;
        logic          arm, hit_rd, hit_wr, sel_wr;
        logic [1:0]    inc;
        logic [CW-1:0] cnt;

        assign sel_wr = wr_any && (bus_addr == ADDR_W'(A_SEL_BASE + 8'(4 * g)));
        always_ff @(posedge clk) begin
            if (!rst_n)      evt_sel[g] <= '0;
            else if (sel_wr) evt_sel[g] <= bus_wdata[1:0];
        end

        assign arm    = run && en_mask[g];
        assign hit_rd = arm && evt_sel[g][SEL_RD] && rd_beat;
        assign hit_wr = arm && evt_sel[g][SEL_WR] && wr_beat;
        assign inc    = {1'b0, hit_rd} + {1'b0, hit_wr};

        pm_counter #(.W(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (wr_ctrl && bus_wdata[CTRL_EVTCLR]),
            .inc   (inc),
            .count (cnt)
        );
        assign evt_val[g] = WIDE_W'(cnt);
    end

    assign wide_cnt = evt_val[NUM_EVT-1];

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(A_CTRL))
            rd_mux = DATA_W'(run);
        if (bus_addr == ADDR_W'(A_EN_SET) || bus_addr == ADDR_W'(A_EN_CLR))
            rd_mux = DATA_W'(en_mask);
        if (bus_addr == ADDR_W'(A_CYC))
            rd_mux = DATA_W'(cyc_cnt);
        if (bus_addr == ADDR_W'(A_WIDE_HI))
            rd_mux = DATA_W'(wide_cnt[WIDE_W-1:CNT_W]);
        for (int i = 0; i < NUM_EVT; i++) begin
            if (bus_addr == ADDR_W'(A_SEL_BASE + 8'(4 * i)))
                rd_mux = DATA_W'(evt_sel[i]);
            if (bus_addr == ADDR_W'(A_EVT_BASE + 8'(4 * i)))
                rd_mux = DATA_W'(evt_val[i][CNT_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_any) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter int WIDE_W = 40,
    parameter int N_EN   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              run,
    input logic [N_EN-1:0]   en_mask,
    input logic [CNT_W-1:0]  cyc_cnt,
    input logic [WIDE_W-1:0] wide_cnt
);
    logic ctrl_w, set_w, clr_w, any_clr;
    assign ctrl_w  = bus_valid && bus_write && (bus_addr == ADDR_W'(8'h00));
    assign set_w   = bus_valid && bus_write && (bus_addr == ADDR_W'(8'h04));
    assign clr_w   = bus_valid && bus_write && (bus_addr == ADDR_W'(8'h08));
    assign any_clr = ctrl_w && (bus_wdata[1] || bus_wdata[2]);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> (bus_rdata == '0));

    a_r2_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        set_w |=> ((en_mask & $past(bus_wdata[N_EN-1:0])) == $past(bus_wdata[N_EN-1:0])));

    a_r2_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> ((en_mask & $past(bus_wdata[N_EN-1:0])) == '0));

    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !any_clr) |=> ($stable(cyc_cnt) && $stable(wide_cnt)));

    a_r5_evt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w && bus_wdata[1]) |=> (wide_cnt == '0));

    a_r6_cyc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w && bus_wdata[2]) |=> (cyc_cnt == '0));

    a_r7_step_limit: assert property (@(posedge clk) disable iff (!rst_n)
        !any_clr |=> (WIDE_W'(wide_cnt - $past(wide_cnt)) <= WIDE_W'(2)));

    a_r9_cyc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !any_clr |=> (CNT_W'(cyc_cnt - $past(cyc_cnt)) <= CNT_W'(1)));
endmodule

bind perf_mon_unit pm_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .WIDE_W (WIDE_W),
    .N_EN   (N_EN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .run       (run),
    .en_mask   (en_mask),
    .cyc_cnt   (cyc_cnt),
    .wide_cnt  (wide_cnt)
);

// File: tb/tb_perf_mon_unit.sv
module tb_perf_mon_unit;
    localparam int CW = 12;
    localparam int HW = 4;
    localparam longint unsigned CMASK = (64'd1 << CW) - 1;
    localparam longint unsigned WMASK = (64'd1 << (CW + HW)) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rd_beat = 1'b0, wr_beat = 1'b0;

    int checks = 0, fails = 0, cycles = 0;
    string phase = "R1", exp_tag = "R1";
    bit    live = 0;

    bit [4:0]        m_mask;
    bit              m_run;
    bit [1:0]        m_sel [4];
    longint unsigned m_ev [4];
    longint unsigned m_cyc;
    logic [31:0]     exp_rd = '0;

    perf_mon_unit #(.CNT_W(CW), .HI_W(HW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rd_beat(rd_beat), .wr_beat(wr_beat));

    always #10 clk = ~clk;

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h00: return {31'b0, m_run};
            8'h04, 8'h08: return {27'b0, m_mask};
            8'h10, 8'h14, 8'h18, 8'h1C: return {30'b0, m_sel[(a - 8'h10) >> 2]};
            8'h20: return 32'(m_cyc);
            8'h24, 8'h28, 8'h2C, 8'h30: return 32'(m_ev[(a - 8'h24) >> 2] & CMASK);
            8'h34: return 32'(m_ev[3] >> CW);
            default: return 32'h0;
        endcase
    endfunction

    // behavioural reference, evaluated on every rising edge
    always @(posedge clk) begin
        live = 1;
        exp_tag = phase;
        if (!rst_n) begin
            m_mask = '0; m_run = 0; m_cyc = 0; exp_rd = '0;
            for (int i = 0; i < 4; i++) begin m_sel[i] = '0; m_ev[i] = 0; end
        end else begin
            exp_rd = (bus_valid && !bus_write) ? m_read(bus_addr) : 32'h0;
            if (m_run) begin
                if (m_mask[4]) m_cyc = (m_cyc + 1) & CMASK;
                for (int i = 0; i < 4; i++)
                    if (m_mask[i])
                        m_ev[i] = (m_ev[i] + ((m_sel[i][0] && rd_beat) ? 1 : 0)
                                   + ((m_sel[i][1] && wr_beat) ? 1 : 0)) & ((i == 3) ? WMASK : CMASK);
            end
            if (bus_valid && bus_write) begin
                case (bus_addr)
                    8'h00: begin
                        m_run = bus_wdata[0];
                        if (bus_wdata[1]) for (int i = 0; i < 4; i++) m_ev[i] = 0;
                        if (bus_wdata[2]) m_cyc = 0;
                    end
                    8'h04: m_mask = m_mask | bus_wdata[4:0];
                    8'h08: m_mask = m_mask & ~bus_wdata[4:0];
                    8'h10, 8'h14, 8'h18, 8'h1C: m_sel[(bus_addr - 8'h10) >> 2] = bus_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        cycles++;
        if (live) begin
            checks++;
            if (bus_rdata !== exp_rd) begin
                fails++;
                $display("FAIL %s: bus_rdata actual %h expected %h (cycle %0d)", exp_tag, bus_rdata, exp_rd, cycles);
            end
        end
        if (cycles > 190000) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    function automatic logic [7:0] addr_at(int k);
        int j = k % 15;
        if (j < 3) return 8'(4 * j);
        if (j < 7) return 8'(8'h10 + 4 * (j - 3));
        if (j < 14) return 8'(8'h20 + 4 * (j - 7));
        return 8'h3C;
    endfunction

    task automatic bus_op(bit v, bit w, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_op(1, 1, a, d);
    endtask

    task automatic rd(logic [7:0] a);
        bus_op(1, 0, a, 32'h0);
    endtask

    // n cycles of beats (mode 0 random, 1 both every cycle) with rotating reads
    task automatic traffic(int n, int mode);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rd_beat = (mode == 1) ? 1'b1 : 1'($urandom % 2);
            wr_beat = (mode == 1) ? 1'b1 : 1'($urandom % 2);
            bus_valid = (k % 5 != 4); bus_write = 0; bus_addr = addr_at(k); bus_wdata = '0;
        end
        @(negedge clk);
        rd_beat = 0; wr_beat = 0; bus_valid = 0;
    endtask

    initial begin
        phase = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int k = 0; k < 15; k++) rd(addr_at(k));
        bus_op(0, 0, 8'h0, 0);
        phase = "R10";
        rd(8'h3C); rd(8'h80); rd(8'hFC); rd(8'h01);
        bus_op(0, 0, 8'h20, 0); bus_op(0, 1, 8'h20, 0);
        phase = "R2";
        wr(8'h04, 32'hFFFF_FF15); rd(8'h04); rd(8'h08);
        wr(8'h08, 32'h0000_0004); rd(8'h04);
        wr(8'h04, 32'h0); rd(8'h08); wr(8'h08, 32'h0); rd(8'h04);
        wr(8'h04, 32'h0000_000A); rd(8'h08);
        phase = "R7";
        wr(8'h10, 1); wr(8'h14, 2); wr(8'h18, 3); wr(8'h1C, 3);
        for (int i = 0; i < 4; i++) rd(8'(8'h10 + 4 * i));
        wr(8'h04, 32'h1F);
        phase = "R11";
        @(negedge clk); rd_beat = 1; wr_beat = 1;
        wr(8'h00, 1);
        rd(8'h24); rd(8'h30);
        phase = "R9";
        traffic(300, 0);
        phase = "R4";
        wr(8'h00, 0);
        traffic(100, 0);
        phase = "R3";
        wr(8'h08, 32'h12);
        wr(8'h00, 1);
        traffic(150, 0);
        wr(8'h04, 32'h10); wr(8'h00, 0); rd(8'h00);
        phase = "R5";
        @(negedge clk); rd_beat = 1; wr_beat = 1;
        wr(8'h00, 3); rd(8'h00); rd(8'h24); rd(8'h30); rd(8'h20);
        traffic(60, 0);
        phase = "R6";
        wr(8'h00, 5); rd(8'h00); rd(8'h20);
        traffic(60, 0);
        wr(8'h00, 7); rd(8'h20); rd(8'h34);
        phase = "R8";
        traffic(33500, 1);
        wr(8'h00, 0);
        for (int k = 0; k < 15; k++) rd(addr_at(k));
        bus_op(0, 0, 8'h0, 0);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule